// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Timer

This block produces up to eight edge-aligned pulse-width-modulated outputs from one shared up-counter. The counter takes its count enable from one of three sources: every system clock cycle, a fixed-rate tick strobe, or an external tick strobe. A power-of-two prescaler divides that enable. The counter runs from a programmable start value up to a programmable limit and then reloads, so every channel has the same period. Each channel compares the count with its own compare value to make its pulse. Each channel also has its own mask bit, which forces the inactive level, and its own inversion bit.

Software programs the block through a flat word-addressed register port. Reads are combinational. A new limit or compare value is held in a shadow register and is only used from the next counter reload, so a period that is already running always completes. Writing the counter register restarts the period at once. The fixed and external clocks are single-cycle strobes in the system clock domain.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset the mask register reads 0xFF and the control, counter, limit, start, polarity, init, channel configuration and compare registers read 0. All outputs are low.
- R2: Byte offsets are: control 0x00, counter 0x04, limit 0x08, channel n configuration 0x0C+8n (bits 5:0) and compare 0x10+8n, start 0x4C, init 0x5C, mask 0x60, polarity 0x70. A read returns the last value written (the pending value for limit and compare).
- R3: Control bits 4:3 select the count source: 0 stopped (the counter holds), 1 every system cycle, 2 one step per `fix_tick` strobe, 3 one step per `ext_tick` strobe. The strobe that is not selected has no effect.
- R4: Control bits 2:0 hold an exponent PS. The counter advances once per 2^PS selected source ticks.
- R5: The counter counts from the start value up to the limit inclusive, then reloads to the start value on the next step. The period is limit-start+1 steps.
- R6: Limit and compare writes take effect only at the next reload. The current period is neither cut short nor re-thresholded.
- R7: Writing any value to the counter offset loads the start value into the counter at once, clears the prescaler and applies the pending limit and compare values.
- R8: A configuration with bit 5 and bit 3 set gives a high-true pulse: the channel is active while count < compare. Bit 5 and bit 2 set with bit 3 clear gives the low-true complement. Any other configuration holds the channel inactive (raw level 0).
- R9: A compare of 0 gives a constant inactive output. A compare above the limit gives a constant active output.
- R10: A set mask bit forces that channel's output to its inactive level, which is the channel's polarity bit.
- R11: A set polarity bit inverts that channel's output.
- R12: While the counter is stopped, each channel's raw level is its init register bit.
- R13: Each output is registered. It reflects the counter and register state one clock edge after that state appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (8) | Register byte offset for reads and writes |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Combinational read data for `addr` |
| fix_tick | input | 1 | Fixed-rate count strobe |
| ext_tick | input | 1 | External count strobe |
| pwm_out | output | NUM_CH (8) | Channel outputs |

## Verification
A register write lands on the clock edge that samples `wr_en`, and a read of the same offset is valid from the next falling edge. A counter step lands on the edge that samples the selected strobe. A channel output follows one edge after the counter. Step-exact checks therefore use the external strobe: each strobe is driven for one falling-to-falling window, and the bench waits two falling edges before it samples an output, except for one check that samples both the stale and the updated value. Duty checks on the free-running source count high samples over a whole number of periods, so they do not depend on phase.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

   typedef enum logic [1:0] {
      SRC_OFF = 2'd0,
      SRC_SYS = 2'd1,
      SRC_FIX = 2'd2,
      SRC_EXT = 2'd3
   } src_e;

   typedef enum logic [1:0] {
      CH_OFF  = 2'd0,
      CH_HIGH = 2'd1,
      CH_LOW  = 2'd2
   } chmode_e;

   // register byte offsets (decoded by software drivers)
   localparam int A_CTL    = 'h00;
   localparam int A_CNT    = 'h04;
   localparam int A_LIM    = 'h08;
   localparam int A_CFG0   = 'h0C;
   localparam int A_CMP0   = 'h10;
   localparam int A_STRIDE = 8;
   localparam int A_START  = 'h4C;
   localparam int A_INIT   = 'h5C;
   localparam int A_MASK   = 'h60;
   localparam int A_POL    = 'h70;

   localparam int CFG_W      = 6;
   localparam int CFG_EDGE_B = 5;
   localparam int CFG_HI_B   = 3;
   localparam int CFG_LO_B   = 2;

   // sel = {edge, high, low}
   function automatic chmode_e decode_mode(input logic [2:0] sel);
      if (sel[2] && sel[1])      return CH_HIGH;
      else if (sel[2] && sel[0]) return CH_LOW;
      else                       return CH_OFF;
   endfunction

endpackage

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
   import pwmt_pkg::*;
#(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  src_e            src,
   input  logic [PS_W-1:0] ps,
   input  logic            fix_tick,
   input  logic            ext_tick,
   input  logic            clr,
   output logic            step
);
   localparam int DIV_W = (1 << PS_W) - 1;

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] div_mask;
   logic             sel_tick;

   always_comb begin
      unique case (src)
         SRC_SYS: sel_tick = 1'b1;
         SRC_FIX: sel_tick = fix_tick;
         SRC_EXT: sel_tick = ext_tick;
         default: sel_tick = 1'b0;
      endcase
   end

   assign div_mask = ~({DIV_W{1'b1}} << ps);
   assign step     = sel_tick && ((div_q & div_mask) == div_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        div_q <= '0;
      else if (clr)      div_q <= '0;
      else if (sel_tick) div_q <= div_q + 1'b1;
   end

endmodule

// File: rtl/pwmt_count.sv
module pwmt_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             load,
   input  logic [CNT_W-1:0] start_val,
   input  logic [CNT_W-1:0] lim_next,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] lim_act,
   output logic             reload
);
   logic wrap;

   assign wrap   = step && (cnt >= lim_act);
   assign reload = load || wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         lim_act <= '0;
      end else begin
         if (reload)    cnt <= start_val;
         else if (step) cnt <= cnt + 1'b1;
         if (reload)    lim_act <= lim_next;
      end
   end

endmodule

// File: rtl/pwmt_chan.sv
module pwmt_chan
   import pwmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload,
   input  logic [CNT_W-1:0] cmp_next,
   input  logic [CNT_W-1:0] cnt,
   input  logic [2:0]       mode_sel,
   input  logic             running,
   input  logic             init_lvl,
   input  logic             mask,
   input  logic             pol,
   output logic             out
);
   logic [CNT_W-1:0] cmp_act;
   logic             below;
   logic             raw;
   chmode_e          mode;

   assign mode  = decode_mode(mode_sel);
   assign below = cnt < cmp_act;

   always_comb begin
      if (!running) raw = init_lvl;
      else begin
         unique case (mode)
            CH_HIGH: raw = below;
            CH_LOW:  raw = !below;
            default: raw = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act <= '0;
         out     <= 1'b0;
      end else begin
         if (reload) cmp_act <= cmp_next;
         out <= mask ? pol : (raw ^ pol);
      end
   end

endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
   import pwmt_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int PS_W   = 3,
   parameter int AW     = 8,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic              fix_tick,
   input  logic              ext_tick,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int CTL_W = PS_W + 2;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_nch
      $error("NUM_CH must be 1..8");
   end
   if (CNT_W < 2 || CNT_W > DW) begin : g_bad_cntw
      $error("CNT_W must be 2..DW");
   end
   if (PS_W < 1 || PS_W > 4) begin : g_bad_psw
      $error("PS_W must be 1..4");
   end
   if (AW < 7 || DW < 8) begin : g_bad_bus
      $error("AW must be >= 7 and DW >= 8");
   end

   logic [CTL_W-1:0]  ctl_q;
   logic [CNT_W-1:0]  lim_q;
   logic [CNT_W-1:0]  start_q;
   logic [NUM_CH-1:0] mask_q;
   logic [NUM_CH-1:0] pol_q;
   logic [NUM_CH-1:0] init_q;
   logic [CFG_W-1:0]  cfg_q [NUM_CH];
   logic [CNT_W-1:0]  cmp_q [NUM_CH];

   src_e              src;
   logic [PS_W-1:0]   ps;
   logic              cnt_load;
   logic              step;
   logic              reload;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  lim_act;
   logic              running;
   logic              unused_wdata;

   assign src          = src_e'(ctl_q[CTL_W-1 -: 2]);
   assign ps           = ctl_q[PS_W-1:0];
   assign running      = (src != SRC_OFF);
   assign cnt_load     = wr_en && (addr == AW'(A_CNT));
   assign unused_wdata = ^wdata;

   // register writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q   <= '0;
         lim_q   <= '0;
         start_q <= '0;
         mask_q  <= '1;
         pol_q   <= '0;
         init_q  <= '0;
         for (int i = 0; i < NUM_CH; i++) begin
            cfg_q[i] <= '0;
            cmp_q[i] <= '0;
         end
      end else if (wr_en) begin
         case (addr)
            AW'(A_CTL):   ctl_q   <= wdata[CTL_W-1:0];
            AW'(A_LIM):   lim_q   <= wdata[CNT_W-1:0];
            AW'(A_START): start_q <= wdata[CNT_W-1:0];
            AW'(A_MASK):  mask_q  <= wdata[NUM_CH-1:0];
            AW'(A_POL):   pol_q   <= wdata[NUM_CH-1:0];
            AW'(A_INIT):  init_q  <= wdata[NUM_CH-1:0];
            default: ;
         endcase
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == AW'(A_CFG0 + A_STRIDE * i)) cfg_q[i] <= wdata[CFG_W-1:0];
            if (addr == AW'(A_CMP0 + A_STRIDE * i)) cmp_q[i] <= wdata[CNT_W-1:0];
         end
      end
   end

   // register reads
   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_CTL):   rdata = DW'(ctl_q);
         AW'(A_CNT):   rdata = DW'(cnt);
         AW'(A_LIM):   rdata = DW'(lim_q);
         AW'(A_START): rdata = DW'(start_q);
         AW'(A_MASK):  rdata = DW'(mask_q);
         AW'(A_POL):   rdata = DW'(pol_q);
         AW'(A_INIT):  rdata = DW'(init_q);
         default: ;
      endcase
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == AW'(A_CFG0 + A_STRIDE * i)) rdata = DW'(cfg_q[i]);
         if (addr == AW'(A_CMP0 + A_STRIDE * i)) rdata = DW'(cmp_q[i]);
      end
   end

   pwmt_prescale #(.PS_W(PS_W)) i_prescale (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src),
      .ps       (ps),
      .fix_tick (fix_tick),
      .ext_tick (ext_tick),
      .clr      (cnt_load),
      .step     (step)
   );

   pwmt_count #(.CNT_W(CNT_W)) i_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .load      (cnt_load),
      .start_val (start_q),
      .lim_next  (lim_q),
      .cnt       (cnt),
      .lim_act   (lim_act),
      .reload    (reload)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      pwmt_chan #(.CNT_W(CNT_W)) i_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .reload   (reload),
         .cmp_next (cmp_q[g]),
         .cnt      (cnt),
         .mode_sel ({cfg_q[g][CFG_EDGE_B], cfg_q[g][CFG_HI_B], cfg_q[g][CFG_LO_B]}),
         .running  (running),
         .init_lvl (init_q[g]),
         .mask     (mask_q[g]),
         .pol      (pol_q[g]),
         .out      (pwm_out[g])
      );
   end

endmodule

// File: rtl/pwmt_chk.sv
module pwmt_chk #(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        src,
   input logic              cnt_load,
   input logic              step,
   input logic              reload,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  lim_act,
   input logic [CNT_W-1:0]  start_q,
   input logic [NUM_CH-1:0] mask_q,
   input logic [NUM_CH-1:0] pol_q,
   input logic [NUM_CH-1:0] pwm_out
);

   p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (src == 2'd0 && !cnt_load) |=> $stable(cnt));

   p_step_incr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_load && cnt < lim_act) |=> cnt == $past(cnt) + 1'b1);

   p_wrap_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !cnt_load && cnt >= lim_act) |=> cnt == $past(start_q));

   p_limit_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !reload |=> $stable(lim_act));

   p_load_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |=> cnt == $past(start_q));

   for (genvar g = 0; g < NUM_CH; g++) begin : g_mask
      p_mask_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
         mask_q[g] |=> pwm_out[g] == $past(pol_q[g]));
   end

endmodule

bind shared_pwm_timer pwmt_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_pwmt_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .src      (ctl_q[CTL_W-1 -: 2]),
   .cnt_load (cnt_load),
   .step     (step),
   .reload   (reload),
   .cnt      (cnt),
   .lim_act  (lim_act),
   .start_q  (start_q),
   .mask_q   (mask_q),
   .pol_q    (pol_q),
   .pwm_out  (pwm_out)
);

// File: tb/test_shared_pwm_timer.sv
`timescale 1ns/1ps
module test_shared_pwm_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fix_tick = 1'b0;
   logic        ext_tick = 1'b0;
   logic [7:0]  pwm_out;

   int checks = 0;
   int errors = 0;
   int hi_cnt [8];
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   shared_pwm_timer i_shared_pwm_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .fix_tick(fix_tick), .ext_tick(ext_tick), .pwm_out(pwm_out)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      addr = 8'(a); wdata = 32'(d); wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      addr = 8'(a);
      #1 d = rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ext(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); ext_tick = 1'b1;
         @(negedge clk); ext_tick = 1'b0;
      end
   endtask

   task automatic pulse_fix(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); fix_tick = 1'b1;
         @(negedge clk); fix_tick = 1'b0;
      end
   endtask

   task automatic count_highs(input int n);
      for (int c = 0; c < 8; c++) hi_cnt[c] = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         for (int c = 0; c < 8; c++) hi_cnt[c] += int'(pwm_out[c]);
      end
   endtask

   task automatic t_reset;
      settle(1);
      check("R1 outputs", 32'(pwm_out), 32'h0);
      rd('h60, rv); check("R1 mask", rv, 32'hFF);
      rd('h00, rv); check("R1 ctl", rv, 32'h0);
      rd('h04, rv); check("R1 cnt", rv, 32'h0);
      rd('h08, rv); check("R1 lim", rv, 32'h0);
      rd('h10, rv); check("R1 cmp0", rv, 32'h0);
   endtask

   task automatic t_regs;
      wr('h08, 'h1234); wr('h24, 'h28); wr('h38, 'h0777);
      wr('h70, 'h5A);   wr('h5C, 'hA5); wr('h4C, 'h0003);
      rd('h08, rv); check("R2 lim", rv, 32'h1234);
      rd('h24, rv); check("R2 cfg3", rv, 32'h28);
      rd('h38, rv); check("R2 cmp5", rv, 32'h0777);
      rd('h70, rv); check("R2 pol", rv, 32'h5A);
      rd('h5C, rv); check("R2 init", rv, 32'hA5);
      rd('h4C, rv); check("R2 start", rv, 32'h3);
      wr('h08, 0); wr('h24, 0); wr('h38, 0);
      wr('h70, 0); wr('h5C, 0); wr('h4C, 0);
   endtask

   task automatic t_duty;
      // ch0..3 high-true, ch4 low-true, ch5 mode bit only
      wr('h0C, 'h28); wr('h14, 'h28); wr('h1C, 'h28); wr('h24, 'h28);
      wr('h2C, 'h24); wr('h34, 'h20);
      wr('h10, 3); wr('h18, 7); wr('h20, 0); wr('h28, 12); wr('h30, 3); wr('h38, 3);
      wr('h08, 9);
      wr('h60, 'hC0);
      wr('h04, 0);
      wr('h00, 'h08);
      settle(4);
      count_highs(20);
      check("R8 ch0 cmp3 duty", 32'(hi_cnt[0]), 32'd6);
      check("R5 ch1 cmp7 duty", 32'(hi_cnt[1]), 32'd14);
      check("R9 ch2 cmp0 inactive", 32'(hi_cnt[2]), 32'd0);
      check("R9 ch3 cmp>lim active", 32'(hi_cnt[3]), 32'd20);
      check("R8 ch4 low-true", 32'(hi_cnt[4]), 32'd14);
      check("R8 ch5 mode off", 32'(hi_cnt[5]), 32'd0);
      wr('h70, 'h01);
      settle(3);
      count_highs(20);
      check("R11 ch0 inverted", 32'(hi_cnt[0]), 32'd14);
      wr('h70, 'h02); wr('h60, 'hC2);
      settle(3);
      count_highs(20);
      check("R10 ch1 masked pol1", 32'(hi_cnt[1]), 32'd20);
      check("R11 ch0 restored", 32'(hi_cnt[0]), 32'd6);
      wr('h70, 'h00);
      settle(3);
      count_highs(20);
      check("R10 ch1 masked pol0", 32'(hi_cnt[1]), 32'd0);
   endtask

   task automatic t_prescale;
      wr('h00, 'h0A);   // system source, PS=2
      settle(8);
      count_highs(40);
      check("R4 ch0 prescaled duty", 32'(hi_cnt[0]), 32'd12);
      check("R4 ch3 prescaled active", 32'(hi_cnt[3]), 32'd40);
   endtask

   task automatic t_ext;
      wr('h00, 'h18);   // external source, PS=0
      wr('h04, 0);
      pulse_fix(3);
      rd('h04, rv); check("R3 fix ignored in ext mode", rv, 32'd0);
      pulse_ext(5);
      rd('h04, rv); check("R3 ext steps", rv, 32'd5);
      // output timing
      wr('h04, 0);
      pulse_ext(2);
      settle(2);
      check("R13 ch0 active at cnt2", 32'(pwm_out[0]), 32'd1);
      @(negedge clk); ext_tick = 1'b1;
      @(negedge clk); ext_tick = 1'b0;
      check("R13 ch0 one edge late", 32'(pwm_out[0]), 32'd1);
      @(negedge clk);
      check("R13 ch0 cleared at match", 32'(pwm_out[0]), 32'd0);
      // shadowing
      pulse_ext(2);     // cnt 5
      wr('h08, 3); wr('h10, 8);
      settle(2);
      check("R6 cmp pending", 32'(pwm_out[0]), 32'd0);
      pulse_ext(4);
      rd('h04, rv); check("R6 period not cut", rv, 32'd9);
      pulse_ext(1);
      rd('h04, rv); check("R5 reload to start", rv, 32'd0);
      settle(1);
      check("R6 cmp applied at reload", 32'(pwm_out[0]), 32'd1);
      pulse_ext(3);
      rd('h04, rv); check("R6 new limit reached", rv, 32'd3);
      pulse_ext(1);
      rd('h04, rv); check("R6 new limit wraps", rv, 32'd0);
      // counter write
      wr('h4C, 2); wr('h08, 9); wr('h10, 1);
      wr('h04, 'h55);
      rd('h04, rv); check("R7 counter write loads start", rv, 32'd2);
      settle(1);
      check("R7 cmp applied by counter write", 32'(pwm_out[0]), 32'd0);
      pulse_ext(7);
      rd('h04, rv); check("R7 limit applied by counter write", rv, 32'd9);
      pulse_ext(1);
      rd('h04, rv); check("R5 wrap to nonzero start", rv, 32'd2);
   endtask

   task automatic t_stop;
      wr('h00, 'h00);
      pulse_ext(2);
      rd('h04, rv); check("R3 stopped counter holds", rv, 32'd2);
      wr('h5C, 'h01);
      settle(2);
      check("R12 init level high", 32'(pwm_out[0]), 32'd1);
      wr('h5C, 'h00);
      settle(2);
      check("R12 init level low", 32'(pwm_out[0]), 32'd0);
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regs;
      t_duty;
      t_prescale;
      t_ext;
      t_stop;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule